// File: doc/BRIEF.md
# Dual-Supply Undervoltage Output Gate

This block sits between the input filters and the output buffers of a half-bridge gate driver. It takes the filtered high-side and low-side drive commands. It passes them through only while the supplies are healthy. Two supplies are watched. The logic supply feeds the low side and the control logic, so losing it blocks both channels and pulls an active-low fault line. The floating supply feeds only the high-side stage, so losing it blocks only the high-side output.

Each supply arrives as two digital comparator flags. One flag says the supply is above its upper (rising) threshold. The other says it has dropped below its lower (falling) threshold. A lockout register per supply turns those two flags into a hysteretic state. The block also watches a flag that reports a negative excursion of the switch node. When that excursion lasts long enough to count as real, the high side is held off for a fixed time. The qualification time and the hold time are both parameters counted in clock cycles.

Top module: `supply_lockout_gate`

## Requirements
- R1: Out of reset both supplies are locked out. `driveHigh`, `driveLow` and `faultN` stay 0 whatever the commands are, until the matching upper-threshold flag has been sampled high.
- R2: When `logicBelowFall` is sampled high on a clock edge, both `driveHigh` and `driveLow` are 0 from that edge on. They stay 0 until `logicAboveRise` is sampled high with `logicBelowFall` low.
- R3: `faultN` is 0 exactly while the logic-supply lockout is set. It returns to 1 on the edge that clears that lockout.
- R4: A lockout register changes state only on its flags. With neither flag high it keeps its state. If both flags are high on the same edge, the lockout is set.
- R5: The floating-supply lockout follows the rules of R1, R2 and R4 through `floatAboveRise` and `floatBelowFall`. It forces only `driveHigh` to 0 and leaves `faultN` unchanged.
- R6: Suppose `negSwing` is sampled high on more than QUAL_CYCLES consecutive edges. On the edge where the run reaches QUAL_CYCLES+1, the hold-off starts. `driveHigh` is then 0 for the next HOLD_CYCLES clock periods. A run of QUAL_CYCLES edges or fewer has no effect. One run starts the hold-off only once.
- R7: With no lockout and no hold-off active, `driveHigh` equals `cmdHigh` and `driveLow` equals `cmdLow` in the same cycle. There is no register delay between command and output.
- R8: `driveLow` is never blocked by the floating-supply lockout or by the hold-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdHigh | input | 1 | Filtered high-side command |
| cmdLow | input | 1 | Filtered low-side command |
| logicAboveRise | input | 1 | Logic supply above its upper threshold |
| logicBelowFall | input | 1 | Logic supply below its lower threshold |
| floatAboveRise | input | 1 | Floating supply above its upper threshold |
| floatBelowFall | input | 1 | Floating supply below its lower threshold |
| negSwing | input | 1 | Switch node beyond its negative excursion limit |
| driveHigh | output | 1 | Gated high-side drive |
| driveLow | output | 1 | Gated low-side drive |
| faultN | output | 1 | Active-low logic-supply fault |

## Verification
Some rules can be checked on every cycle from the ports alone, and the assertions cover these:
- a sampled lower-threshold flag blocks the right outputs on the next cycle;
- an output is never high without its command;
- the fault line never rises unless an upper-threshold flag was seen;
- a qualified swing blocks the high side on the following cycle.

Other behaviour needs a sequence of cycles, so only the bench scenarios show it:
- a lockout persists through the dead band between the two thresholds;
- "fall wins" when both flags are high together;
- a run one edge too short has no effect;
- the hold-off lasts exactly its length, and one long run does not start it again.

// File: rtl/supply_lockout_pkg.sv
package supply_lockout_pkg;

  // Strobes from the control half to the gating datapath.
  typedef struct packed {
    logic blockBoth;   // logic-supply lockout: both channels off, fault on
    logic blockHigh;   // floating-supply lockout or swing hold-off
  } gateStrobes_t;

  localparam int SUPPLY_COUNT = 2;
  localparam int SUP_LOGIC    = 0;
  localparam int SUP_FLOAT    = 1;

endpackage

// File: rtl/hyst_lockout.sv
module hyst_lockout (
  input  logic clk,
  input  logic rstN,
  input  logic aboveRise,
  input  logic belowFall,
  output logic locked
);
  // Set by the lower threshold, cleared only by the upper one; set wins.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          locked <= 1'b1;
    else if (belowFall) locked <= 1'b1;
    else if (aboveRise) locked <= 1'b0;
  end
endmodule

// File: rtl/lockout_ctrl.sv
module lockout_ctrl
  import supply_lockout_pkg::*;
#(
  parameter int QUAL_CYCLES = 7,
  parameter int HOLD_CYCLES = 563
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         logicAboveRise,
  input  logic         logicBelowFall,
  input  logic         floatAboveRise,
  input  logic         floatBelowFall,
  input  logic         negSwing,
  output gateStrobes_t strobes
);
  localparam int QW = $clog2(QUAL_CYCLES + 2);
  localparam int HW = $clog2(HOLD_CYCLES + 1);

  logic [SUPPLY_COUNT-1:0] riseVec, fallVec, lockVec;
  assign riseVec = {floatAboveRise, logicAboveRise};
  assign fallVec = {floatBelowFall, logicBelowFall};

  for (genvar s = 0; s < SUPPLY_COUNT; s++) begin : g_sup
    hyst_lockout u_lock (
      .clk      (clk),
      .rstN     (rstN),
      .aboveRise(riseVec[s]),
      .belowFall(fallVec[s]),
      .locked   (lockVec[s])
    );
  end

  // Swing qualifier: counts consecutive high samples, saturating past the limit.
  logic [QW-1:0] runCnt;
  logic [HW-1:0] holdCnt;
  logic          qualHit;

  assign qualHit = negSwing && (runCnt == QW'(QUAL_CYCLES));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               runCnt <= '0;
    else if (!negSwing)                      runCnt <= '0;
    else if (runCnt <= QW'(QUAL_CYCLES))     runCnt <= runCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               holdCnt <= '0;
    else if (qualHit)        holdCnt <= HW'(HOLD_CYCLES);
    else if (holdCnt != '0)  holdCnt <= holdCnt - 1'b1;
  end

  assign strobes.blockBoth = lockVec[SUP_LOGIC];
  assign strobes.blockHigh = lockVec[SUP_FLOAT] | (holdCnt != '0);
endmodule

// File: rtl/gate_datapath.sv
module gate_datapath
  import supply_lockout_pkg::*;
(
  input  logic         cmdHigh,
  input  logic         cmdLow,
  input  gateStrobes_t strobes,
  output logic         driveHigh,
  output logic         driveLow,
  output logic         faultN
);
  always_comb begin
    driveLow  = cmdLow  & ~strobes.blockBoth;
    driveHigh = cmdHigh & ~strobes.blockBoth & ~strobes.blockHigh;
    faultN    = ~strobes.blockBoth;
  end
endmodule

// File: rtl/supply_lockout_gate.sv
module supply_lockout_gate
  import supply_lockout_pkg::*;
#(
  parameter int QUAL_CYCLES = 7,
  parameter int HOLD_CYCLES = 563
) (
  input  logic clk,
  input  logic rstN,
  input  logic cmdHigh,
  input  logic cmdLow,
  input  logic logicAboveRise,
  input  logic logicBelowFall,
  input  logic floatAboveRise,
  input  logic floatBelowFall,
  input  logic negSwing,
  output logic driveHigh,
  output logic driveLow,
  output logic faultN
);
  gateStrobes_t strobes;

  lockout_ctrl #(.QUAL_CYCLES(QUAL_CYCLES), .HOLD_CYCLES(HOLD_CYCLES)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .logicAboveRise(logicAboveRise),
    .logicBelowFall(logicBelowFall),
    .floatAboveRise(floatAboveRise),
    .floatBelowFall(floatBelowFall),
    .negSwing      (negSwing),
    .strobes       (strobes)
  );

  gate_datapath u_dp (
    .cmdHigh  (cmdHigh),
    .cmdLow   (cmdLow),
    .strobes  (strobes),
    .driveHigh(driveHigh),
    .driveLow (driveLow),
    .faultN   (faultN)
  );
endmodule

// File: rtl/supply_lockout_checker.sv
module supply_lockout_checker #(
  parameter int QUAL_CYCLES = 7
) (
  input logic clk,
  input logic rstN,
  input logic cmdHigh,
  input logic cmdLow,
  input logic logicAboveRise,
  input logic logicBelowFall,
  input logic floatAboveRise,
  input logic floatBelowFall,
  input logic negSwing,
  input logic driveHigh,
  input logic driveLow,
  input logic faultN
);
  localparam int CW = $clog2(QUAL_CYCLES + 2);
  logic [CW-1:0] seenRun;

  // Independent count of consecutive swing samples.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             seenRun <= '0;
    else if (!negSwing)                    seenRun <= '0;
    else if (seenRun <= CW'(QUAL_CYCLES))  seenRun <= seenRun + 1'b1;
  end

  a_r2_logic_drop_blocks_both: assert property (@(posedge clk) disable iff (!rstN)
    $past(logicBelowFall) |-> (!driveHigh && !driveLow));

  a_r3_fault_on_logic_drop: assert property (@(posedge clk) disable iff (!rstN)
    $past(logicBelowFall) |-> !faultN);

  a_r4_fault_release_needs_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultN) |-> $past(logicAboveRise));

  a_r5_float_drop_blocks_high: assert property (@(posedge clk) disable iff (!rstN)
    $past(floatBelowFall) |-> !driveHigh);

  a_r6_swing_holdoff_starts: assert property (@(posedge clk) disable iff (!rstN)
    (negSwing && seenRun == CW'(QUAL_CYCLES)) |=> !driveHigh);

  a_r7_outputs_follow_cmds: assert property (@(posedge clk) disable iff (!rstN)
    (!driveHigh || cmdHigh) && (!driveLow || cmdLow));

  a_r3_low_off_while_fault: assert property (@(posedge clk) disable iff (!rstN)
    !faultN |-> !driveLow);
endmodule

bind supply_lockout_gate supply_lockout_checker #(.QUAL_CYCLES(QUAL_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .cmdHigh(cmdHigh), .cmdLow(cmdLow),
  .logicAboveRise(logicAboveRise), .logicBelowFall(logicBelowFall),
  .floatAboveRise(floatAboveRise), .floatBelowFall(floatBelowFall),
  .negSwing(negSwing), .driveHigh(driveHigh), .driveLow(driveLow), .faultN(faultN)
);

// File: tb/test_supply_lockout_gate.sv
module test_supply_lockout_gate;
  localparam int QUAL = 3;
  localparam int HOLD = 20;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdHigh = 0, cmdLow = 0, lRise = 0, lFall = 0, fRise = 0, fFall = 0, swing = 0;
  logic driveHigh, driveLow, faultN;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;  // 125 MHz

  supply_lockout_gate #(.QUAL_CYCLES(QUAL), .HOLD_CYCLES(HOLD)) i_supply_lockout_gate (
    .clk(clk), .rstN(rstN), .cmdHigh(cmdHigh), .cmdLow(cmdLow),
    .logicAboveRise(lRise), .logicBelowFall(lFall),
    .floatAboveRise(fRise), .floatBelowFall(fFall), .negSwing(swing),
    .driveHigh(driveHigh), .driveLow(driveLow), .faultN(faultN)
  );

  // Reference state built from the requirements.
  bit mLogicLock, mFloatLock;
  int mRun, mHold;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mLogicLock <= 1; mFloatLock <= 1; mRun <= 0; mHold <= 0;
    end else begin
      if (lFall) mLogicLock <= 1; else if (lRise) mLogicLock <= 0;
      if (fFall) mFloatLock <= 1; else if (fRise) mFloatLock <= 0;
      if (swing) begin
        mRun <= mRun + 1;
        if (mRun + 1 == QUAL + 1) mHold <= HOLD;
        else if (mHold > 0) mHold <= mHold - 1;
      end else begin
        mRun <= 0;
        if (mHold > 0) mHold <= mHold - 1;
      end
    end
  end

  function automatic bit expHigh();
    return cmdHigh && !mLogicLock && !mFloatLock && (mHold == 0);
  endfunction
  function automatic bit expLow();
    return cmdLow && !mLogicLock;
  endfunction

  task automatic check(string tag);
    bit eh = expHigh(), el = expLow(), ef = !mLogicLock;
    tests++;
    if (driveHigh !== eh || driveLow !== el || faultN !== ef) begin
      fails++;
      $display("FAIL %s: hi/lo/faultN actual %b%b%b expected %b%b%b",
               tag, driveHigh, driveLow, faultN, eh, el, ef);
    end
  endtask

  task automatic drive(bit ch, bit cl, bit lr, bit lf, bit fr, bit ff, bit sw);
    cmdHigh = ch; cmdLow = cl; lRise = lr; lFall = lf; fRise = fr; fFall = ff; swing = sw;
  endtask

  task automatic stepCheck(bit ch, bit cl, bit lr, bit lf, bit fr, bit ff, bit sw, string tag);
    drive(ch, cl, lr, lf, fr, ff, sw);
    @(negedge clk);
    check(tag);
  endtask

  function automatic string autoTag();
    if (mLogicLock) return "R2";
    if (mFloatLock) return "R5";
    if (mHold != 0) return "R6";
    return "R7";
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    drive(1, 1, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rstN = 1'b1;
    for (int i = 0; i < 3; i++) stepCheck(1, 1, 0, 0, 0, 0, 0, "R1 no rise yet");
    // Logic up only: low side works, floating supply still blocks high side.
    stepCheck(1, 1, 1, 0, 0, 0, 0, "R5 float still locked");
    stepCheck(1, 0, 0, 0, 1, 0, 0, "R7 both up");
    stepCheck(0, 1, 0, 0, 0, 0, 0, "R7 in phase");
    stepCheck(1, 1, 0, 0, 0, 0, 0, "R7 in phase");
    // Logic drop, then dead band holds lockout.
    stepCheck(1, 1, 0, 1, 0, 0, 0, "R2 logic drop");
    stepCheck(1, 1, 0, 0, 0, 0, 0, "R4 dead band holds");
    stepCheck(1, 1, 0, 0, 1, 0, 0, "R3 fault persists");
    stepCheck(1, 1, 1, 1, 0, 0, 0, "R4 both flags fall wins");
    stepCheck(1, 1, 1, 0, 0, 0, 0, "R3 fault release");
    // Floating drop: only high side.
    stepCheck(1, 1, 0, 0, 0, 1, 0, "R5 float drop");
    stepCheck(1, 1, 0, 0, 0, 0, 0, "R8 low unaffected by float");
    stepCheck(1, 1, 0, 0, 1, 0, 0, "R5 float recover");
    // Short swing: QUAL samples, no effect.
    for (int i = 0; i < QUAL; i++) stepCheck(1, 1, 0, 0, 0, 0, 1, "R6 short run");
    stepCheck(1, 1, 0, 0, 0, 0, 0, "R6 short run ignored");
    // Long swing: hold-off for HOLD periods, once per run.
    for (int i = 0; i < QUAL + 1 + HOLD + 4; i++)
      stepCheck(1, 1, 0, 0, 0, 0, 1, (i > QUAL) ? "R6 hold" : "R8 low during swing");
    stepCheck(1, 1, 0, 0, 0, 0, 0, "R6 after hold");
    // Constrained random.
    for (int i = 0; i < 4000; i++) begin
      bit sw = swing;
      if ($urandom_range(7) == 0) sw = !sw;
      drive($urandom_range(1), $urandom_range(1),
            $urandom_range(3) == 0, $urandom_range(24) == 0,
            $urandom_range(3) == 0, $urandom_range(20) == 0, sw);
      @(negedge clk);
      check(autoTag());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule